// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block connects a synchronous request port to an external asynchronous static RAM that holds 32768 bytes. A client offers one request at a time. Each request carries a write flag, a 15-bit address and 8 bits of write data, and it is taken when valid and ready are both high. The controller turns the request into one strobe sequence on the memory pins. A read drives chip enable and output enable low and keeps write enable high. A write keeps output enable high and pulses write enable low, so the write is controlled by write enable. The controller returns read data with a one-cycle valid pulse.

The data bus is split into an output value, an input value and a driver enable, so the pad ring builds the tristate. The length of every phase comes from nanosecond limits passed as parameters. Each limit is divided by the clock period, rounded up, and never allowed below one cycle. The controller keeps the shared bus free of two drivers at once. It enables its own driver only after output enable has been high long enough for the memory outputs to reach high impedance. It releases the driver one cycle after write enable returns high. Throughout every cycle, chip enable stays low and the address is held.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever chip enable is high, write enable and output enable are high, the data driver is off, request ready is high and read-valid is low.
- R2: A read holds chip enable and output enable low, with write enable high, for RD_CYC = max(1, ceil(T_RC_NS / CLK_NS)) cycles. The data on the bus in the last of those cycles is returned on rsp_rdata_o, and rsp_valid_o is high for exactly one cycle. That cycle is the one in which ready has returned high.
- R3: During a write, write enable is low for exactly WL_CYC = max(WP_CYC, DW_CYC) consecutive cycles. Here WP_CYC and DW_CYC are the rounded-up pulse-width and data-setup limits. Output enable stays high and chip enable stays low throughout, and the driver carries the request data for the whole pulse.
- R4: The data driver turns on only after output enable has been high for at least OEZ_CYC = max(1, ceil(T_OEZ_NS / CLK_NS)) cycles in a row. It is still on in the first cycle after write enable rises, and off in the cycle after that.
- R5: The driver is never on while chip enable and output enable are both low.
- R6: Ready goes low in the cycle after a request is taken. For a read it stays low for RD_CYC cycles, and for a write for OEZ_CYC + WL_CYC + 1 cycles, after which it returns high.
- R7: The memory address does not change while chip enable stays low.
- R8: A read returns the byte most recently written to the same address. This holds for the lowest and highest address, for all-zero and all-one data, and for alternating bit patterns.
- R9: An asynchronous reset in the middle of a write returns all three strobes high and turns the driver off at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle; request taken when valid is also high |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 8 | Captured read data |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_addr_o | output | 15 | Memory address |
| sram_dq_o | output | 8 | Data to memory |
| sram_dq_i | input | 8 | Data from memory |
| sram_dq_oe_o | output | 1 | Data driver enable |

## Verification
A wrong sequencer state shows at the pins in the very next cycle. Possible signs are a write pulse shorter or longer than WL_CYC, output enable low while the controller drives the bus, or a driver turned on too early after a read. A bus-watching model flags each of these in the cycle it occurs. Faults in the turnaround count or the capture point appear as a wrong busy length, a missing read-valid pulse, or data that disagrees with earlier writes, and these show in the transaction that follows. Random traffic over the whole address range, checked against a shadow copy, catches address or data corruption within one read of the affected location.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD
  } ctrl_state_e;

  // ceil(ns / clk), never below one cycle
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk);
    int unsigned c;
    c = (ns + clk - 1) / clk;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC  = 1,
  parameter int OEZ_CYC = 1,
  parameter int WL_CYC  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_we_i,
  output logic ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);

  localparam int MAXC = max2(max2(RD_CYC, OEZ_CYC), WL_CYC);
  localparam int CW   = $clog2(MAXC + 1);

  ctrl_state_e   state_q, state_d;
  logic          load;
  logic [CW-1:0] load_val;
  logic          tmr_done;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (tmr_done)
  );

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_val  = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          load     = 1'b1;
          if (req_we_i) begin
            state_d  = ST_WR_TURN;
            load_val = CW'(OEZ_CYC - 1);
          end else begin
            state_d  = ST_RD;
            load_val = CW'(RD_CYC - 1);
          end
        end
      end
      ST_RD: begin
        if (tmr_done) begin
          capture_o = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WR_TURN: begin
        if (tmr_done) begin
          state_d  = ST_WR_PULSE;
          load     = 1'b1;
          load_val = CW'(WL_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (tmr_done) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // strobes registered from next state: no decode glitches on the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_no   <= 1'b1;
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      ce_no   <= (state_d == ST_IDLE);
      we_no   <= (state_d != ST_WR_PULSE);
      oe_no   <= (state_d != ST_RD);
      dq_oe_o <= (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    end
  end

  assign ready_o = (state_q == ST_IDLE);

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] sram_dq_i,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sram_addr_o <= '0;
      sram_dq_o   <= '0;
    end else if (accept_i) begin
      sram_addr_o <= req_addr_i;
      sram_dq_o   <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= capture_i;
      if (capture_i) rsp_rdata_o <= sram_dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 12,
  parameter int T_WP_NS   = 10,
  parameter int T_DW_NS   = 6,
  parameter int T_OEZ_NS  = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          sram_ce_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe_o
);

  localparam int RD_CYC  = ns2cyc(T_RC_NS, CLK_NS);
  localparam int WP_CYC  = ns2cyc(T_WP_NS, CLK_NS);
  localparam int DW_CYC  = ns2cyc(T_DW_NS, CLK_NS);
  localparam int OEZ_CYC = ns2cyc(T_OEZ_NS, CLK_NS);
  // data is driven from the first pulse cycle, so the pulse also covers setup
  localparam int WL_CYC  = max2(WP_CYC, DW_CYC);

  logic accept, capture;

  sram_ctrl_seq #(
    .RD_CYC  (RD_CYC),
    .OEZ_CYC (OEZ_CYC),
    .WL_CYC  (WL_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .ce_no       (sram_ce_no),
    .we_no       (sram_we_no),
    .oe_no       (sram_oe_no),
    .dq_oe_o     (sram_dq_oe_o)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .capture_i   (capture),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .sram_dq_i   (sram_dq_i),
    .sram_addr_o (sram_addr_o),
    .sram_dq_o   (sram_dq_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW      = 15,
  parameter int OEZ_CYC = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          sram_ce_no,
  input logic          sram_we_no,
  input logic          sram_oe_no,
  input logic [AW-1:0] sram_addr_o,
  input logic          sram_dq_oe_o
);

  localparam int OW = $clog2(OEZ_CYC + 2);

  logic [OW-1:0] oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        oe_hi_cnt <= '0;
    else if (!sram_oe_no)               oe_hi_cnt <= '0;
    else if (oe_hi_cnt < OW'(OEZ_CYC))  oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  p_deselect_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no |-> (sram_we_no && sram_oe_no && !sram_dq_oe_o));

  p_rvalid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_write_oe_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_oe_no && !sram_ce_no && sram_dq_oe_o));

  p_drive_after_oez_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (oe_hi_cnt >= OW'(OEZ_CYC)));

  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> sram_dq_oe_o ##1 !sram_dq_oe_o);

  p_no_contention_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_dq_oe_o && !sram_ce_no && !sram_oe_no));

  p_busy_after_accept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .OEZ_CYC(OEZ_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .sram_ce_no   (sram_ce_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_addr_o  (sram_addr_o),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;

  localparam int CLK_NS = 20;
  localparam int RC_NS = 45, WP_NS = 50, DWS_NS = 30, OEZ_NS = 25;
  // expected counts, worked out here from the requirements
  localparam int E_RD  = (RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_WP  = (WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_DWS = (DWS_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_OEZ = (OEZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int E_WL  = (E_WP > E_DWS) ? E_WP : E_DWS;
  localparam int E_WBUSY = E_OEZ + E_WL + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic ce_n, we_n, oe_n, dq_oe;
  logic [14:0] m_addr;
  logic [7:0] dq_o, dq_i;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl #(
    .CLK_NS(CLK_NS), .T_RC_NS(RC_NS), .T_WP_NS(WP_NS),
    .T_DW_NS(DWS_NS), .T_OEZ_NS(OEZ_NS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .sram_ce_no(ce_n), .sram_we_no(we_n), .sram_oe_no(oe_n),
    .sram_addr_o(m_addr), .sram_dq_o(dq_o), .sram_dq_i(dq_i),
    .sram_dq_oe_o(dq_oe)
  );

  // memory model: sparse, drives only in read mode
  logic [7:0] mem [logic [14:0]];
  logic [7:0] shadow [logic [14:0]];

  function automatic logic [7:0] mem_rd(input logic [14:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always_comb dq_i = (!ce_n && !oe_n && we_n) ? mem_rd(m_addr) : 8'h00;

  // bus monitor, sampled away from the active edge
  int e_contention = 0, e_wr_oe_low = 0, e_wr_nodrive = 0, e_wlen = 0;
  int e_early = 0, e_release = 0, e_addr = 0, e_rvwide = 0;
  int we_run = 0, oe_run = 0;
  logic prev_we = 1'b1, prev_ce = 1'b1, prev_dqoe = 1'b0, prev_rv = 1'b0;
  logic rel_pend = 1'b0;
  logic [14:0] prev_addr = '0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      we_run = 0; oe_run = 0; prev_we = 1'b1; prev_ce = 1'b1;
      prev_dqoe = 1'b0; prev_rv = 1'b0; rel_pend = 1'b0;
    end else begin
      if (dq_oe && !ce_n && !oe_n) e_contention++;
      if (!ce_n && !we_n) begin
        if (!oe_n) e_wr_oe_low++;
        if (!dq_oe) e_wr_nodrive++;
        mem[m_addr] = dq_o;
      end
      if (rel_pend) begin
        if (dq_oe) e_release++;
        rel_pend = 1'b0;
      end
      if (we_n && !prev_we) begin
        if (we_run != E_WL) e_wlen++;
        if (!dq_oe) e_release++;
        rel_pend = 1'b1;
      end
      if (dq_oe && !prev_dqoe && oe_run < E_OEZ) e_early++;
      if (!ce_n && !prev_ce && m_addr != prev_addr) e_addr++;
      if (rsp_valid && prev_rv) e_rvwide++;
      we_run = !we_n ? we_run + 1 : 0;
      oe_run = oe_n ? oe_run + 1 : 0;
      prev_we = we_n; prev_ce = ce_n; prev_dqoe = dq_oe;
      prev_rv = rsp_valid; prev_addr = m_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic we, input logic [14:0] a, input logic [7:0] d,
                         output int busy, output logic got_v, output logic [7:0] got_d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      busy++;
      @(negedge clk);
    end
    got_v = rsp_valid;
    got_d = rsp_rdata;
  endtask

  // {we, addr, wdata, expected read}
  localparam int NV = 14;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 15'h0000, 8'hA5, 8'h00},
    {1'b1, 15'h7FFF, 8'h3C, 8'h00},
    {1'b0, 15'h0000, 8'h00, 8'hA5},
    {1'b0, 15'h7FFF, 8'h00, 8'h3C},
    {1'b1, 15'h1234, 8'hFF, 8'h00},
    {1'b0, 15'h1234, 8'h00, 8'hFF},
    {1'b1, 15'h1234, 8'h00, 8'h00},
    {1'b0, 15'h1234, 8'h00, 8'h00},
    {1'b0, 15'h0155, 8'h00, 8'h00},
    {1'b1, 15'h4AAA, 8'h5A, 8'h00},
    {1'b1, 15'h2555, 8'hC3, 8'h00},
    {1'b0, 15'h4AAA, 8'h00, 8'h5A},
    {1'b0, 15'h2555, 8'h00, 8'hC3},
    {1'b0, 15'h0000, 8'h00, 8'hA5}
  };

  initial begin
    int busy;
    logic gv;
    logic [7:0] gd;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce_n == 1'b1, "R1 ce", ce_n, 1);
    chk(we_n == 1'b1 && oe_n == 1'b1, "R1 we/oe", {we_n, oe_n}, 3);
    chk(dq_oe == 1'b0, "R1 driver", dq_oe, 0);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready/valid", {req_ready, rsp_valid}, 2);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic w;
      w = VEC[i][31];
      run_req(w, VEC[i][30:16], VEC[i][15:8], busy, gv, gd);
      if (w) begin
        shadow[VEC[i][30:16]] = VEC[i][15:8];
        chk(busy == E_WBUSY, "R6 write busy", busy, E_WBUSY);
        chk(gv == 1'b0, "R2 no valid on write", gv, 0);
      end else begin
        chk(busy == E_RD, "R6 read busy", busy, E_RD);
        chk(gv == 1'b1, "R2 read valid", gv, 1);
        chk(gd == VEC[i][7:0], "R8 table read data", gd, VEC[i][7:0]);
      end
    end

    // R9 reset in the middle of a write pulse
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 15'h0100; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    while (we_n) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(ce_n && we_n && oe_n, "R9 strobes", {ce_n, we_n, oe_n}, 7);
    chk(dq_oe == 1'b0, "R9 driver", dq_oe, 0);
    chk(req_ready == 1'b1, "R9 ready", req_ready, 1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R8 random traffic against shadow copy
    for (int n = 0; n < 80; n++) begin
      logic w;
      logic [14:0] a;
      logic [7:0] d, e;
      w = $urandom_range(0, 1) == 1;
      a = (n % 3 == 0) ? VEC[n % NV][30:16] : 15'($urandom);
      if (a == 15'h0100) a = 15'h0101;
      d = 8'($urandom);
      run_req(w, a, d, busy, gv, gd);
      if (w) shadow[a] = d;
      else begin
        e = shadow.exists(a) ? shadow[a] : 8'h00;
        chk(gv && gd == e, "R8 random read", {gv, gd}, {1'b1, e});
      end
    end

    repeat (4) @(negedge clk);
    chk(e_contention == 0, "R5 contention", e_contention, 0);
    chk(e_wr_oe_low == 0, "R3 write with oe low", e_wr_oe_low, 0);
    chk(e_wr_nodrive == 0, "R3 write without driver", e_wr_nodrive, 0);
    chk(e_wlen == 0, "R3 pulse length", e_wlen, 0);
    chk(e_early == 0, "R4 early driver", e_early, 0);
    chk(e_release == 0, "R4 release timing", e_release, 0);
    chk(e_addr == 0, "R7 address moved", e_addr, 0);
    chk(e_rvwide == 0, "R2 valid width", e_rvwide, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule